// File: doc/BRIEF.md
# Gather Copy Datapath

This block moves data described by transfer descriptors. A destination buffer (a buffer address plus the address of its descriptor slot) is taken from a destination queue. Source descriptors then arrive one at a time, each naming a source address, a byte count and a flags half-word. The data of each source descriptor is copied word by word into the destination buffer through a single word-wide memory port. A descriptor may carry a chaining flag, so that the next descriptor's data continues in the same destination buffer. This lets several scattered source pieces gather into one destination buffer.

Each piece can have the bytes of every 32-bit word reversed. A partial final word is written with byte enables only. A running byte total is checked against a per-engine destination limit. Empty or oversized pieces raise error pulses and are not copied.

When a chain ends, the block writes a completion word into the destination descriptor slot. The same cycle raises a completion pulse that carries the total length and the transfer id. Optional per-descriptor bits can mute the host-side or target-side notification.

Top module: `gather_copy_engine`

## Requirements
- R1: After reset, `cmpl_valid`, `err_src_len`, `err_max_len` and `mem_req` are 0, `src_ready` is 0 and `dst_ready` is 1.
- R2: A source descriptor is two words. In `src_word0`, bits 31:2 are the word address of the data and bits 1:0 are ignored. `src_word1` holds the byte count in bits 15:0 and the flags in bits 31:16. When `cfg_src_desc_swap` is 1, the bytes of each word are reversed before these fields are taken.
- R3: A descriptor with byte count n copies ceil(n/4) words from consecutive source word addresses to consecutive destination word addresses. Each read (`mem_req`=1, `mem_we`=0) is followed in the next cycle by the write of that word. Read data is expected on `mem_rdata` one cycle after the read request.
- R4: When n mod 4 = k is not 0, the last word is written with only the lowest k byte enables set (`mem_be` bit i enables byte lane i, bits 8i+7:8i). Destination bytes beyond the count are left unchanged.
- R5: Flags bit 1 reverses the byte order inside each copied word before the partial-word masking is applied.
- R6: Flags bit 0 chains: the next descriptor's data goes into the same destination buffer. It starts at the first word after the words already written. No new destination is taken, and no completion is raised until a descriptor with bit 0 clear has been handled.
- R7: At the end of a chain, one full word (`mem_be`=4'hF) is written to `dst_desc_addr`+4. Its bits 15:0 hold the chain's total byte count. Its bits 31:16 hold the last descriptor's flags with bit 0 cleared. Its bytes are reversed when `cfg_dst_desc_swap` is 1. `cmpl_valid` pulses in that same cycle, and `cmpl_len` equals the total.
- R8: When `cfg_irq_bits_en` is 0, `cmpl_id` is flags bits 15:2 and both notify outputs equal `cmpl_valid`. When it is 1, `cmpl_id` is flags bits 15:4 zero-extended. In that mode, flags bit 2 mutes `cmpl_host_irq` and flags bit 3 mutes `cmpl_tgt_irq`.
- R9: A descriptor with byte count 0 makes no memory access. It pulses `err_src_len` one cycle after it is accepted, and it still counts as a piece of the chain.
- R10: A descriptor that would raise the chain total above `cfg_max_len` is not copied. It pulses `err_max_len` one cycle after acceptance and adds nothing to the total.
- R11: `dst_ready` is 1 only between chains and `src_ready` only while a destination is held, so a destination is never taken in the middle of a chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_max_len | input | 16 | Destination byte limit per chain |
| cfg_irq_bits_en | input | 1 | Flags bits 3:2 act as notify mutes; id moves to bits 15:4 |
| cfg_src_desc_swap | input | 1 | Byte-reverse incoming descriptor words |
| cfg_dst_desc_swap | input | 1 | Byte-reverse the completion word |
| src_valid | input | 1 | Source descriptor offered |
| src_ready | output | 1 | Source descriptor accepted when valid |
| src_word0 | input | 32 | Source data address |
| src_word1 | input | 32 | Flags (31:16) and byte count (15:0) |
| dst_valid | input | 1 | Destination buffer offered |
| dst_ready | output | 1 | Destination accepted when valid |
| dst_buf_addr | input | 32 | Destination buffer byte address (word aligned) |
| dst_desc_addr | input | 32 | Destination descriptor byte address |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables |
| mem_rdata | input | 32 | Read data, one cycle after a read |
| cmpl_valid | output | 1 | Chain completion pulse |
| cmpl_len | output | 16 | Chain total byte count |
| cmpl_id | output | 14 | Transfer id of the last descriptor |
| cmpl_host_irq | output | 1 | Host-side notification |
| cmpl_tgt_irq | output | 1 | Target-side notification |
| err_src_len | output | 1 | Zero-length descriptor pulse |
| err_max_len | output | 1 | Destination limit violation pulse |

## Verification
The bench targets partial final words with and without swapping. A design that masks before swapping, or enables the wrong lanes, leaves wrong bytes in the buffer. Gather chains with odd-sized middle pieces expose a write pointer that packs bytes or forgets to advance, and an early or repeated completion. Zero-length and limit-exceeding pieces, placed alone and mid-chain, catch a design that touches memory or counts their bytes. The two id layouts and both descriptor swap enables catch field extraction taken from the wrong bits.

// File: rtl/gce_pkg.sv
package gce_pkg;

    localparam int WORD_BYTES = 4;
    localparam int LEN_W      = 16;
    localparam int FLG_W      = 16;
    localparam int ID_W       = 14;

    localparam int FLG_CHAIN   = 0;
    localparam int FLG_SWAP    = 1;
    localparam int FLG_MUTE_H  = 2;
    localparam int FLG_MUTE_T  = 3;

    typedef struct packed {
        logic [31:0]      addr;
        logic [LEN_W-1:0] nbytes;
        logic [FLG_W-1:0] flags;
    } src_desc_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_SRC,
        ST_RD,
        ST_WR,
        ST_SEG_END,
        ST_REC
    } seq_state_t;

    function automatic logic [31:0] swap32(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic logic [WORD_BYTES-1:0] tail_lanes(input logic [1:0] k);
        logic [WORD_BYTES-1:0] m;
        for (int i = 0; i < WORD_BYTES; i++) begin
            m[i] = (k == 2'd0) || (i < int'(k));
        end
        return m;
    endfunction

endpackage

// File: rtl/gce_desc_unpack.sv
module gce_desc_unpack
    import gce_pkg::*;
(
    input  logic [31:0] word0,
    input  logic [31:0] word1,
    input  logic        swap_en,
    output src_desc_t   desc
);
    logic [31:0] w0;
    logic [31:0] w1;

    always_comb begin
        w0          = swap_en ? swap32(word0) : word0;
        w1          = swap_en ? swap32(word1) : word1;
        desc.addr   = {w0[31:2], 2'b00};
        desc.nbytes = w1[LEN_W-1:0];
        desc.flags  = w1[31:16];
    end
endmodule

// File: rtl/gce_lane_xform.sv
module gce_lane_xform
    import gce_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0]         rdata,
    input  logic                  swap_en,
    input  logic                  last_word,
    input  logic [1:0]            tail,
    output logic [DW-1:0]         wdata,
    output logic [DW/8-1:0]       be
);
    logic [DW-1:0] ordered;

    always_comb begin
        ordered = swap_en ? swap32(rdata) : rdata;
        be      = last_word ? tail_lanes(tail) : '1;
    end

    for (genvar g = 0; g < DW/8; g++) begin : g_lane
        assign wdata[8*g +: 8] = be[g] ? ordered[8*g +: 8] : 8'h00;
    end
endmodule

// File: rtl/gce_seq.sv
module gce_seq
    import gce_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LEN_W-1:0] max_len,
    input  logic             src_valid,
    input  src_desc_t        desc,
    input  logic             dst_valid,
    input  logic [AW-1:0]    dst_buf_addr,
    input  logic [AW-1:0]    dst_desc_addr,
    output logic             src_ready,
    output logic             dst_ready,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic             wr_data_phase,
    output logic             rec_phase,
    output logic             seg_swap,
    output logic             last_word,
    output logic [1:0]       tail,
    output logic [LEN_W-1:0] total,
    output logic [FLG_W-1:0] last_flags,
    output logic             err_zero,
    output logic             err_limit
);
    localparam int WA_W   = AW - 2;
    localparam int WCNT_W = LEN_W - 1;

    seq_state_t        state;
    logic [WA_W-1:0]   src_wa;
    logic [WA_W-1:0]   dst_wa;
    logic [WA_W-1:0]   rec_wa;
    logic [WCNT_W-1:0] words_left;
    logic [LEN_W:0]    sum_next;
    logic [LEN_W:0]    words_calc;

    assign sum_next   = {1'b0, total} + {1'b0, desc.nbytes};
    assign words_calc = ({1'b0, desc.nbytes} + (LEN_W+1)'(WORD_BYTES - 1)) >> 2;

    assign dst_ready     = (state == ST_IDLE);
    assign src_ready     = (state == ST_WAIT_SRC);
    assign wr_data_phase = (state == ST_WR);
    assign rec_phase     = (state == ST_REC);
    assign mem_req       = (state == ST_RD) || (state == ST_WR) || (state == ST_REC);
    assign mem_we        = (state == ST_WR) || (state == ST_REC);
    assign seg_swap      = last_flags[FLG_SWAP];
    assign last_word     = (words_left == WCNT_W'(1));

    always_comb begin
        case (state)
            ST_RD:   mem_addr = {src_wa, 2'b00};
            ST_WR:   mem_addr = {dst_wa, 2'b00};
            ST_REC:  mem_addr = {rec_wa + WA_W'(1), 2'b00};
            default: mem_addr = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            src_wa     <= '0;
            dst_wa     <= '0;
            rec_wa     <= '0;
            words_left <= '0;
            tail       <= '0;
            total      <= '0;
            last_flags <= '0;
            err_zero   <= 1'b0;
            err_limit  <= 1'b0;
        end else begin
            err_zero  <= 1'b0;
            err_limit <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (dst_valid) begin
                        dst_wa <= dst_buf_addr[AW-1:2];
                        rec_wa <= dst_desc_addr[AW-1:2];
                        total  <= '0;
                        state  <= ST_WAIT_SRC;
                    end
                end
                ST_WAIT_SRC: begin
                    if (src_valid) begin
                        last_flags <= desc.flags;
                        src_wa     <= desc.addr[AW-1:2];
                        words_left <= words_calc[WCNT_W-1:0];
                        tail       <= desc.nbytes[1:0];
                        if (desc.nbytes == '0) begin
                            err_zero <= 1'b1;
                            state    <= ST_SEG_END;
                        end else if (sum_next > {1'b0, max_len}) begin
                            err_limit <= 1'b1;
                            state     <= ST_SEG_END;
                        end else begin
                            total <= sum_next[LEN_W-1:0];
                            state <= ST_RD;
                        end
                    end
                end
                ST_RD: state <= ST_WR;
                ST_WR: begin
                    src_wa     <= src_wa + WA_W'(1);
                    dst_wa     <= dst_wa + WA_W'(1);
                    words_left <= words_left - WCNT_W'(1);
                    state      <= last_word ? ST_SEG_END : ST_RD;
                end
                ST_SEG_END: state <= last_flags[FLG_CHAIN] ? ST_WAIT_SRC : ST_REC;
                ST_REC:     state <= ST_IDLE;
                default:    state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/gather_copy_engine.sv
module gather_copy_engine
    import gce_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] cfg_max_len,
    input  logic        cfg_irq_bits_en,
    input  logic        cfg_src_desc_swap,
    input  logic        cfg_dst_desc_swap,
    input  logic        src_valid,
    output logic        src_ready,
    input  logic [31:0] src_word0,
    input  logic [31:0] src_word1,
    input  logic        dst_valid,
    output logic        dst_ready,
    input  logic [31:0] dst_buf_addr,
    input  logic [31:0] dst_desc_addr,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    output logic [3:0]  mem_be,
    input  logic [31:0] mem_rdata,
    output logic        cmpl_valid,
    output logic [15:0] cmpl_len,
    output logic [13:0] cmpl_id,
    output logic        cmpl_host_irq,
    output logic        cmpl_tgt_irq,
    output logic        err_src_len,
    output logic        err_max_len
);
    localparam int AW = 32;
    localparam int DW = 32;

    src_desc_t        desc;
    logic             wr_phase;
    logic             rec_phase;
    logic             seg_swap;
    logic             last_word;
    logic [1:0]       tail;
    logic [LEN_W-1:0] total;
    logic [FLG_W-1:0] last_flags;
    logic [DW-1:0]    copy_data;
    logic [DW/8-1:0]  copy_be;
    logic [31:0]      rec_word;

    gce_desc_unpack u_unpack (
        .word0   (src_word0),
        .word1   (src_word1),
        .swap_en (cfg_src_desc_swap),
        .desc    (desc)
    );

    gce_seq #(.AW(AW)) u_seq (
        .clk           (clk),
        .rst           (rst),
        .max_len       (cfg_max_len),
        .src_valid     (src_valid),
        .desc          (desc),
        .dst_valid     (dst_valid),
        .dst_buf_addr  (dst_buf_addr),
        .dst_desc_addr (dst_desc_addr),
        .src_ready     (src_ready),
        .dst_ready     (dst_ready),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .wr_data_phase (wr_phase),
        .rec_phase     (rec_phase),
        .seg_swap      (seg_swap),
        .last_word     (last_word),
        .tail          (tail),
        .total         (total),
        .last_flags    (last_flags),
        .err_zero      (err_src_len),
        .err_limit     (err_max_len)
    );

    gce_lane_xform #(.DW(DW)) u_xform (
        .rdata     (mem_rdata),
        .swap_en   (seg_swap),
        .last_word (last_word),
        .tail      (tail),
        .wdata     (copy_data),
        .be        (copy_be)
    );

    always_comb begin
        rec_word = {last_flags & ~(FLG_W'(1) << FLG_CHAIN), total};
        if (cfg_dst_desc_swap) rec_word = swap32(rec_word);
        mem_wdata = rec_phase ? rec_word : (wr_phase ? copy_data : '0);
        mem_be    = rec_phase ? '1 : (wr_phase ? copy_be : '0);
    end

    assign cmpl_valid    = rec_phase;
    assign cmpl_len      = total;
    assign cmpl_id       = cfg_irq_bits_en ? {2'b00, last_flags[15:4]} : last_flags[15:2];
    assign cmpl_host_irq = rec_phase && !(cfg_irq_bits_en && last_flags[FLG_MUTE_H]);
    assign cmpl_tgt_irq  = rec_phase && !(cfg_irq_bits_en && last_flags[FLG_MUTE_T]);
endmodule

// File: rtl/gce_checker.sv
module gce_checker (
    input logic        clk,
    input logic        rst,
    input logic [15:0] cfg_max_len,
    input logic        src_valid,
    input logic        src_ready,
    input logic        dst_ready,
    input logic        mem_req,
    input logic        mem_we,
    input logic [3:0]  mem_be,
    input logic        cmpl_valid,
    input logic [15:0] cmpl_len,
    input logic        cmpl_host_irq,
    input logic        cmpl_tgt_irq,
    input logic        err_src_len,
    input logic        err_max_len
);
    p_read_then_write_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |=> (mem_req && mem_we));

    p_write_has_source_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && !cmpl_valid) |-> $past(mem_req && !mem_we));

    p_record_write_r7: assert property (@(posedge clk) disable iff (rst)
        cmpl_valid |-> (mem_req && mem_we && mem_be == 4'hF));

    p_total_in_limit_r10: assert property (@(posedge clk) disable iff (rst)
        cmpl_valid |-> (cmpl_len <= cfg_max_len));

    p_zero_err_after_accept_r9: assert property (@(posedge clk) disable iff (rst)
        err_src_len |-> $past(src_valid && src_ready));

    p_limit_err_after_accept_r10: assert property (@(posedge clk) disable iff (rst)
        err_max_len |-> $past(src_valid && src_ready));

    p_notify_inside_cmpl_r8: assert property (@(posedge clk) disable iff (rst)
        (cmpl_host_irq || cmpl_tgt_irq) |-> cmpl_valid);

    p_no_dst_after_src_r11: assert property (@(posedge clk) disable iff (rst)
        (src_valid && src_ready) |=> !dst_ready);
endmodule

bind gather_copy_engine gce_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .cfg_max_len   (cfg_max_len),
    .src_valid     (src_valid),
    .src_ready     (src_ready),
    .dst_ready     (dst_ready),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_be        (mem_be),
    .cmpl_valid    (cmpl_valid),
    .cmpl_len      (cmpl_len),
    .cmpl_host_irq (cmpl_host_irq),
    .cmpl_tgt_irq  (cmpl_tgt_irq),
    .err_src_len   (err_src_len),
    .err_max_len   (err_max_len)
);

// File: tb/gather_copy_engine_tb.sv
module gather_copy_engine_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cfg_max_len = 16'hFFFF;
    logic        cfg_irq_bits_en = 1'b0;
    logic        cfg_src_desc_swap = 1'b0;
    logic        cfg_dst_desc_swap = 1'b0;
    logic        src_valid = 1'b0;
    logic        src_ready;
    logic [31:0] src_word0 = '0;
    logic [31:0] src_word1 = '0;
    logic        dst_valid = 1'b0;
    logic        dst_ready;
    logic [31:0] dst_buf_addr = '0;
    logic [31:0] dst_desc_addr = '0;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_be;
    logic [31:0] mem_rdata = '0;
    logic        cmpl_valid;
    logic [15:0] cmpl_len;
    logic [13:0] cmpl_id;
    logic        cmpl_host_irq;
    logic        cmpl_tgt_irq;
    logic        err_src_len;
    logic        err_max_len;

    always #2.5 clk = ~clk;

    gather_copy_engine u_dut (.*);

    localparam int MEM_WORDS = 4096;
    localparam int DST_BASE  = 32'h1000;
    localparam int DESC_BASE = 32'h3000;
    localparam int DST_CHECK = 128;
    localparam logic [31:0] SENTINEL = 32'hA5A5A5A5;

    logic [31:0] mem [MEM_WORDS];

    always @(posedge clk) begin
        if (mem_req && mem_we) begin
            for (int b = 0; b < 4; b++)
                if (mem_be[b]) mem[mem_addr[13:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
        end else if (mem_req) begin
            mem_rdata <= mem[mem_addr[13:2]];
        end
    end

    int n_tests = 0;
    int n_fail  = 0;
    int rd_cnt = 0, cmpl_cnt = 0, zerr_cnt = 0, merr_cnt = 0;
    logic [15:0] got_len;
    logic [13:0] got_id;
    logic        got_host, got_tgt;
    bit          done_flag = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_req && !mem_we) rd_cnt++;
            if (err_src_len) zerr_cnt++;
            if (err_max_len) merr_cnt++;
            if (cmpl_valid) begin
                cmpl_cnt++;
                got_len  = cmpl_len;
                got_id   = cmpl_id;
                got_host = cmpl_host_irq;
                got_tgt  = cmpl_tgt_irq;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rev(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    logic [31:0] seg_addr  [4];
    logic [15:0] seg_n     [4];
    logic [15:0] seg_flags [4];
    logic [31:0] exp_dst   [DST_CHECK];

    task automatic send_src(input logic [31:0] w0, input logic [31:0] w1);
        @(negedge clk);
        src_word0 = w0;
        src_word1 = w1;
        src_valid = 1'b1;
        while (!src_ready) @(negedge clk);
        @(negedge clk);
        src_valid = 1'b0;
    endtask

    task automatic run_chain(input int nseg, input logic [15:0] maxl, input bit irqen,
                             input bit sswap, input bit dswap, input string tag);
        int tot = 0, woff = 0, exp_rd = 0, exp_z = 0, exp_m = 0;
        int c0, r0, z0, m0, mism;
        logic [15:0] lf;
        logic [31:0] w1, exp_rec;
        for (int i = 0; i < DST_CHECK; i++) begin
            mem[DST_BASE/4 + i] = SENTINEL;
            exp_dst[i] = SENTINEL;
        end
        mem[DESC_BASE/4 + 1] = 32'h0;
        cfg_max_len = maxl; cfg_irq_bits_en = irqen;
        cfg_src_desc_swap = sswap; cfg_dst_desc_swap = dswap;
        for (int s = 0; s < nseg; s++) begin
            seg_flags[s][0] = (s < nseg - 1);
            if (seg_n[s] == 0) exp_z++;
            else if (tot + int'(seg_n[s]) > int'(maxl)) exp_m++;
            else begin
                int nw = (int'(seg_n[s]) + 3) / 4;
                for (int w = 0; w < nw; w++) begin
                    logic [31:0] sw = mem[seg_addr[s][13:2] + w];
                    int nb = (w == nw - 1 && seg_n[s][1:0] != 0) ? int'(seg_n[s][1:0]) : 4;
                    if (seg_flags[s][1]) sw = rev(sw);
                    for (int b = 0; b < nb; b++) exp_dst[woff + w][8*b +: 8] = sw[8*b +: 8];
                end
                woff += nw; exp_rd += nw; tot += int'(seg_n[s]);
            end
        end
        lf = seg_flags[nseg-1];
        c0 = cmpl_cnt; r0 = rd_cnt; z0 = zerr_cnt; m0 = merr_cnt;
        @(negedge clk);
        dst_buf_addr = DST_BASE; dst_desc_addr = DESC_BASE; dst_valid = 1'b1;
        while (!dst_ready) @(negedge clk);
        @(negedge clk);
        dst_valid = 1'b0;
        for (int s = 0; s < nseg; s++) begin
            w1 = {seg_flags[s], seg_n[s]};
            send_src(sswap ? rev(seg_addr[s]) : seg_addr[s], sswap ? rev(w1) : w1);
            if (s < nseg - 1)
                chk(!dst_ready, "R11", {tag, " dst_ready mid-chain"}, 32'(dst_ready), 0);
        end
        while (cmpl_cnt == c0) @(negedge clk);
        @(negedge clk);
        chk(cmpl_cnt == c0 + 1, "R6", {tag, " completion count"}, cmpl_cnt - c0, 1);
        chk(got_len == 16'(tot), "R7", {tag, " cmpl_len"}, 32'(got_len), tot);
        chk(got_id == (irqen ? {2'b00, lf[15:4]} : lf[15:2]), "R8", {tag, " cmpl_id"},
            32'(got_id), irqen ? 32'(lf[15:4]) : 32'(lf[15:2]));
        chk(got_host == !(irqen && lf[2]), "R8", {tag, " host notify"}, 32'(got_host), 32'(!(irqen && lf[2])));
        chk(got_tgt == !(irqen && lf[3]), "R8", {tag, " target notify"}, 32'(got_tgt), 32'(!(irqen && lf[3])));
        exp_rec = {lf & 16'hFFFE, 16'(tot)};
        if (dswap) exp_rec = rev(exp_rec);
        chk(mem[DESC_BASE/4 + 1] == exp_rec, "R7", {tag, " record word"}, mem[DESC_BASE/4 + 1], exp_rec);
        chk(rd_cnt - r0 == exp_rd, "R3", {tag, " word reads"}, rd_cnt - r0, exp_rd);
        chk(zerr_cnt - z0 == exp_z, "R9", {tag, " zero-length errors"}, zerr_cnt - z0, exp_z);
        chk(merr_cnt - m0 == exp_m, "R10", {tag, " limit errors"}, merr_cnt - m0, exp_m);
        mism = 0;
        for (int i = 0; i < DST_CHECK; i++) begin
            if (mem[DST_BASE/4 + i] !== exp_dst[i]) begin
                if (mism == 0)
                    chk(0, "R4", {tag, " dst data (R2 R5 R6)"}, mem[DST_BASE/4 + i], exp_dst[i]);
                mism++;
            end
        end
        if (mism == 0) chk(1, "R4", {tag, " dst data"}, 0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < MEM_WORDS; i++) mem[i] = $urandom;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!cmpl_valid && !err_src_len && !err_max_len && !mem_req, "R1", "idle outputs",
            {cmpl_valid, err_src_len, err_max_len, mem_req}, 0);
        chk(!src_ready && dst_ready, "R1", "ready pair", {src_ready, dst_ready}, 2'b01);

        seg_addr[0] = 32'h40; seg_n[0] = 16; seg_flags[0] = 16'h1234;
        run_chain(1, 16'hFFFF, 0, 0, 0, "R3 full words");

        seg_addr[0] = 32'h103; seg_n[0] = 7; seg_flags[0] = 16'h00AA;
        run_chain(1, 16'hFFFF, 0, 0, 0, "R2 R4 R5 swap partial");

        seg_addr[0] = 32'h200; seg_n[0] = 8;  seg_flags[0] = 16'h0004;
        seg_addr[1] = 32'h300; seg_n[1] = 5;  seg_flags[1] = 16'h0002;
        seg_addr[2] = 32'h380; seg_n[2] = 3;  seg_flags[2] = 16'hFFF0;
        run_chain(3, 16'hFFFF, 0, 0, 0, "R6 gather");

        seg_addr[0] = 32'h80; seg_n[0] = 0; seg_flags[0] = 16'h0100;
        run_chain(1, 16'hFFFF, 0, 0, 0, "R9 zero alone");

        seg_addr[0] = 32'h80; seg_n[0] = 6; seg_flags[0] = 16'h0000;
        seg_addr[1] = 32'h90; seg_n[1] = 0; seg_flags[1] = 16'h0000;
        seg_addr[2] = 32'hA0; seg_n[2] = 9; seg_flags[2] = 16'h0000;
        run_chain(3, 16'hFFFF, 0, 0, 0, "R9 zero mid-chain");

        seg_addr[0] = 32'h10; seg_n[0] = 16; seg_flags[0] = 16'h0000;
        seg_addr[1] = 32'h20; seg_n[1] = 8;  seg_flags[1] = 16'h0000;
        seg_addr[2] = 32'h30; seg_n[2] = 4;  seg_flags[2] = 16'h5550;
        run_chain(3, 16'd20, 0, 0, 0, "R10 limit");

        seg_addr[0] = 32'h10; seg_n[0] = 20; seg_flags[0] = 16'h0000;
        run_chain(1, 16'd20, 0, 0, 0, "R10 exact limit");

        seg_addr[0] = 32'h60; seg_n[0] = 12; seg_flags[0] = 16'hABC4;
        run_chain(1, 16'hFFFF, 1, 0, 0, "R8 host mute");

        seg_addr[0] = 32'h60; seg_n[0] = 12; seg_flags[0] = 16'hABC8;
        run_chain(1, 16'hFFFF, 1, 0, 0, "R8 target mute");

        seg_addr[0] = 32'h144; seg_n[0] = 10; seg_flags[0] = 16'h7A02;
        run_chain(1, 16'hFFFF, 0, 1, 1, "R2 R7 descriptor swaps");

        for (int t = 0; t < 40; t++) begin
            int ns = 1 + int'($urandom % 4);
            for (int s = 0; s < ns; s++) begin
                seg_addr[s]  = ($urandom % 512) * 4 + ($urandom % 4);
                seg_n[s]     = (($urandom % 8) == 0) ? 16'd0 : 16'(1 + $urandom % 60);
                seg_flags[s] = 16'($urandom);
            end
            run_chain(ns, (($urandom % 3) == 0) ? 16'(32 + $urandom % 100) : 16'hFFFF,
                      1'($urandom), 1'($urandom), 1'($urandom), "random");
        end

        done_flag = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule